// File: doc/BRIEF.md
# Converter Result Read Sequencer

This block fetches conversion results from a four-channel analog-to-digital converter on an I2C bus. A request names one of eight devices on the bus and supplies the channel, the input configuration, the auto-increment flag, the analog-output-enable flag and the number of results wanted. The sequencer drives a byte-level I2C master one command at a time. It addresses the converter for writing, sends a control byte built from the request, and turns the bus around with a repeated start into a read. It throws away the two stale bytes at the head of the read and then streams the wanted results out one byte at a time.

Each master command is held until the master returns a completion pulse with an acknowledge bit and an error bit. A missing acknowledge on an address leads to a clean stop. A bus error or lost arbitration ends the request at once. Every request, successful or not, ends with a single done pulse that carries a pass flag. While a request is in flight, `req_ready` stays low and any new request is ignored.

Top module: `adc_seq`

## Requirements
- R1: After reset `req_ready` is 1 and `cmd_valid`, `done` and `out_valid` are 0.
- R2: Command codes on `cmd_op` are 0 start+write address, 1 write byte, 2 repeated start+read address, 3 read with acknowledge, 4 read without acknowledge, 5 stop. The first command carries the address byte {4'b1001, device[2:0], 1'b0}.
- R3: The second command is a write of the control byte {0, out_en, mode[1:0], 0, auto_inc, chan[1:0]} (bit 7 down to bit 0).
- R4: After the control byte, the next command is a repeated start with address byte {4'b1001, device, 1'b1}, and no stop is issued between the write and the read.
- R5: The two reads that follow the read address both use acknowledge, and their data never reaches `out_data`.
- R6: For a count N, the block issues N-1 acknowledged reads and then one unacknowledged read, followed by a stop. Each of these N bytes appears on `out_data` with `out_valid` high for one cycle, one clock after the master's completion pulse for that read.
- R7: A command's `cmd_op` and `cmd_data` stay stable, with `cmd_valid` high, from the cycle it is raised until the cycle the master returns `cmd_done`.
- R8: If either address byte is not acknowledged, the block issues a stop, then one read without acknowledge whose data is dropped, and ends with a failed done.
- R9: If the control byte is not acknowledged, the block issues a stop and ends with a failed done.
- R10: `cmd_err` on any command ends the request in the next cycle with `done`=1 and `done_ok`=0, and no further command is issued.
- R11: `done` pulses for one cycle, one clock after the completion of the request's last command. `done_ok` is 1 only when every byte up to the final stop completed without error.
- R12: `req_ready` is low from acceptance until the cycle of the done pulse, and a request presented meanwhile is ignored.
- R13: A request with count 0 issues no command and produces a failed done in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_dev | input | 3 | Device select on the bus |
| req_chan | input | 2 | Converter channel |
| req_mode | input | 2 | Input configuration |
| req_autoinc | input | 1 | Channel auto-increment flag |
| req_aout | input | 1 | Analog output enable flag |
| req_count | input | CNT_W | Number of results to return |
| cmd_valid | output | 1 | Command to master pending |
| cmd_op | output | 3 | Command code |
| cmd_data | output | 8 | Byte to send (address or control) |
| cmd_done | input | 1 | Master finished the command |
| cmd_ack | input | 1 | Slave acknowledged the sent byte |
| cmd_err | input | 1 | Bus error or lost arbitration |
| cmd_rdata | input | 8 | Byte received by a read command |
| out_valid | output | 1 | Result byte valid |
| out_data | output | 8 | Result byte |
| done | output | 1 | Request finished |
| done_ok | output | 1 | Request succeeded |

## Verification
A wrong internal state shows at the command port first. An off-by-one in the discard or remaining-byte counting issues an acknowledged read where an unacknowledged one belongs, or emits a discarded byte. The reference model catches this on the very cycle the command appears, because it compares every command against the expected list on every clock. A wrong fault branch shows within one command completion, as an extra or missing stop or dummy read, or a done pulse in the wrong cycle with the wrong pass flag. Output bytes and `req_ready` are checked on the exact cycle they are due, so a lost or shifted pulse is caught immediately.

// File: rtl/adc_seq.sv
module adc_seq #(
  parameter int          CNT_W    = 4,
  parameter logic [3:0]  DEV_BASE = 4'b1001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_dev,
  input  logic [1:0]       req_chan,
  input  logic [1:0]       req_mode,
  input  logic             req_autoinc,
  input  logic             req_aout,
  input  logic [CNT_W-1:0] req_count,
  output logic             cmd_valid,
  output logic [2:0]       cmd_op,
  output logic [7:0]       cmd_data,
  input  logic             cmd_done,
  input  logic             cmd_ack,
  input  logic             cmd_err,
  input  logic [7:0]       cmd_rdata,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             done,
  output logic             done_ok
);
  localparam logic [2:0] OP_START_WR  = 3'd0;
  localparam logic [2:0] OP_WRITE     = 3'd1;
  localparam logic [2:0] OP_RSTART_RD = 3'd2;
  localparam logic [2:0] OP_READ_ACK  = 3'd3;
  localparam logic [2:0] OP_READ_NACK = 3'd4;
  localparam logic [2:0] OP_STOP      = 3'd5;
  localparam logic [CNT_W-1:0] LAST_ONE = CNT_W'(1);

  typedef enum logic [2:0] {
    S_IDLE, S_AW, S_CTRL, S_AR, S_DROP, S_RD, S_STOP, S_DUMMY
  } st_t;

  st_t             st;
  logic [2:0]      dev;
  logic [7:0]      ctrl;
  logic [CNT_W-1:0] rem;
  logic            drop_more;
  logic            pass;
  logic            dummy;

  assign req_ready = (st == S_IDLE);
  assign cmd_valid = (st != S_IDLE);

  always_comb begin
    cmd_op   = OP_STOP;
    cmd_data = 8'h00;
    case (st)
      S_AW:    begin cmd_op = OP_START_WR;  cmd_data = {DEV_BASE, dev, 1'b0}; end
      S_CTRL:  begin cmd_op = OP_WRITE;     cmd_data = ctrl; end
      S_AR:    begin cmd_op = OP_RSTART_RD; cmd_data = {DEV_BASE, dev, 1'b1}; end
      S_DROP:  cmd_op = OP_READ_ACK;
      S_RD:    cmd_op = (rem == LAST_ONE) ? OP_READ_NACK : OP_READ_ACK;
      S_DUMMY: cmd_op = OP_READ_NACK;
      default: cmd_op = OP_STOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      dev       <= '0;
      ctrl      <= '0;
      rem       <= '0;
      drop_more <= 1'b0;
      pass      <= 1'b0;
      dummy     <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      done      <= 1'b0;
      done_ok   <= 1'b0;
    end else begin
      done      <= 1'b0;
      out_valid <= 1'b0;
      if (st == S_IDLE) begin
        if (req_valid) begin
          if (req_count == '0) begin
            done    <= 1'b1;
            done_ok <= 1'b0;
          end else begin
            dev  <= req_dev;
            ctrl <= {1'b0, req_aout, req_mode, 1'b0, req_autoinc, req_chan};
            rem  <= req_count;
            st   <= S_AW;
          end
        end
      end else if (cmd_done) begin
        if (cmd_err) begin
          done    <= 1'b1;
          done_ok <= 1'b0;
          st      <= S_IDLE;
        end else begin
          case (st)
            S_AW, S_AR: begin
              drop_more <= 1'b1;
              if (!cmd_ack) begin
                pass  <= 1'b0;
                dummy <= 1'b1;
                st    <= S_STOP;
              end else begin
                st <= (st == S_AW) ? S_CTRL : S_DROP;
              end
            end
            S_CTRL: begin
              if (!cmd_ack) begin
                pass  <= 1'b0;
                dummy <= 1'b0;
                st    <= S_STOP;
              end else begin
                st <= S_AR;
              end
            end
            S_DROP: begin
              if (drop_more) drop_more <= 1'b0;
              else           st        <= S_RD;
            end
            S_RD: begin
              out_valid <= 1'b1;
              out_data  <= cmd_rdata;
              if (rem == LAST_ONE) begin
                pass  <= 1'b1;
                dummy <= 1'b0;
                st    <= S_STOP;
              end else begin
                rem <= rem - LAST_ONE;
              end
            end
            S_STOP: begin
              if (dummy) begin
                st <= S_DUMMY;
              end else begin
                done    <= 1'b1;
                done_ok <= pass;
                st      <= S_IDLE;
              end
            end
            default: begin
              done    <= 1'b1;
              done_ok <= 1'b0;
              st      <= S_IDLE;
            end
          endcase
        end
      end
    end
  end
endmodule

module adc_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       cmd_valid,
  input logic [2:0] cmd_op,
  input logic [7:0] cmd_data,
  input logic       cmd_done,
  input logic       cmd_ack,
  input logic       cmd_err,
  input logic [7:0] cmd_rdata,
  input logic       out_valid,
  input logic [7:0] out_data,
  input logic       done,
  input logic       done_ok
);
  localparam logic [2:0] OP_START_WR  = 3'd0;
  localparam logic [2:0] OP_RSTART_RD = 3'd2;
  localparam logic [2:0] OP_READ_ACK  = 3'd3;
  localparam logic [2:0] OP_READ_NACK = 3'd4;
  localparam logic [2:0] OP_STOP      = 3'd5;

  // R7
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_done |=> cmd_valid && $stable(cmd_op) && $stable(cmd_data));

  // R6
  out_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(cmd_done) && !$past(cmd_err) &&
      ($past(cmd_op) == OP_READ_ACK || $past(cmd_op) == OP_READ_NACK) &&
      out_data == $past(cmd_rdata));

  // R2
  first_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) |-> cmd_op == OP_START_WR && !cmd_data[0]);

  // R5
  drop_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done && cmd_op == OP_RSTART_RD && cmd_ack && !cmd_err |=>
      cmd_valid && cmd_op == OP_READ_ACK && !out_valid);

  // R10
  err_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done && cmd_err |=> !cmd_valid && done && !done_ok);

  // R11
  pass_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_ok |-> $past(cmd_done) && $past(cmd_op) == OP_STOP);

  // R12
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !req_ready);

  // R8
  addr_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done && !cmd_err && !cmd_ack &&
      (cmd_op == OP_START_WR || cmd_op == OP_RSTART_RD) |=>
      cmd_valid && cmd_op == OP_STOP);
endmodule

bind adc_seq adc_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .cmd_valid(cmd_valid),
  .cmd_op(cmd_op), .cmd_data(cmd_data), .cmd_done(cmd_done), .cmd_ack(cmd_ack),
  .cmd_err(cmd_err), .cmd_rdata(cmd_rdata), .out_valid(out_valid),
  .out_data(out_data), .done(done), .done_ok(done_ok)
);

// File: tb/adc_seq_tb.sv
`timescale 1ns/1ps
module adc_seq_tb;
  localparam int CW = 4;
  localparam logic [2:0] OP_SW = 3'd0, OP_WR = 3'd1, OP_RS = 3'd2,
                         OP_RA = 3'd3, OP_RN = 3'd4, OP_SP = 3'd5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [2:0] req_dev = '0;
  logic [1:0] req_chan = '0, req_mode = '0;
  logic req_autoinc = 1'b0, req_aout = 1'b0;
  logic [CW-1:0] req_count = '0;
  logic cmd_valid;
  logic [2:0] cmd_op;
  logic [7:0] cmd_data;
  logic cmd_done = 1'b0, cmd_ack = 1'b0, cmd_err = 1'b0;
  logic [7:0] cmd_rdata = '0;
  logic out_valid, done, done_ok;
  logic [7:0] out_data;

  always #2 clk = ~clk;

  adc_seq #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_dev(req_dev), .req_chan(req_chan), .req_mode(req_mode),
    .req_autoinc(req_autoinc), .req_aout(req_aout), .req_count(req_count),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .cmd_done(cmd_done), .cmd_ack(cmd_ack), .cmd_err(cmd_err),
    .cmd_rdata(cmd_rdata), .out_valid(out_valid), .out_data(out_data),
    .done(done), .done_ok(done_ok)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [2:0] q_op[$];
  logic [7:0] q_dat[$];
  int    q_flt[$];
  bit    q_emit[$], q_last[$], q_ok[$];
  string q_req[$];
  string q_tag[$];

  int f_idx = -1, f_kind = 0;
  int req_no = 0, rd_n = 0, cmd_seq = 0, lat = 0;
  int n_acc = 0, n_done = 0;
  bit exp_ready = 1;
  bit pend_out = 0, pend_done = 0, pend_ok = 0;
  logic [7:0] pend_val = '0;
  string pend_tag = "R11";

  task automatic chk(input bit cond, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rd_val(input int n, input int t);
    return 8'((n * 37 + t * 11 + 90) & 255);
  endfunction

  task automatic push(input logic [2:0] op, input logic [7:0] d, input int flt,
                      input bit emit, input bit last, input bit ok,
                      input string req, input string tag);
    q_op.push_back(op); q_dat.push_back(d); q_flt.push_back(flt);
    q_emit.push_back(emit); q_last.push_back(last); q_ok.push_back(ok);
    q_req.push_back(req); q_tag.push_back(tag);
  endtask

  function automatic int flt(input int k);
    return (k == f_idx) ? f_kind : 0;
  endfunction

  task automatic build(input logic [2:0] dv, input logic [1:0] ch, input logic [1:0] md,
                       input bit ai, input bit ao, input int cnt);
    int k = 0;
    int fk;
    if (cnt == 0) begin
      pend_done = 1; pend_ok = 0; pend_tag = "R13"; n_done++;
      return;
    end
    exp_ready = 0;
    fk = flt(k); k++;
    push(OP_SW, {4'b1001, dv, 1'b0}, fk, 0, fk == 2, 0, "R2", "R10");
    if (fk == 2) return;
    if (fk == 1) begin
      push(OP_SP, 8'h00, 0, 0, 0, 0, "R8", "R8");
      push(OP_RN, 8'h00, 0, 0, 1, 0, "R8", "R8");
      return;
    end
    fk = flt(k); k++;
    push(OP_WR, {1'b0, ao, md, 1'b0, ai, ch}, fk, 0, fk == 2, 0, "R3", "R10");
    if (fk == 2) return;
    if (fk == 1) begin
      push(OP_SP, 8'h00, 0, 0, 1, 0, "R9", "R9");
      return;
    end
    fk = flt(k); k++;
    push(OP_RS, {4'b1001, dv, 1'b1}, fk, 0, fk == 2, 0, "R4", "R10");
    if (fk == 2) return;
    if (fk == 1) begin
      push(OP_SP, 8'h00, 0, 0, 0, 0, "R8", "R8");
      push(OP_RN, 8'h00, 0, 0, 1, 0, "R8", "R8");
      return;
    end
    for (int d = 0; d < 2; d++) begin
      fk = flt(k); k++;
      push(OP_RA, 8'h00, fk, 0, fk == 2, 0, "R5", "R10");
      if (fk == 2) return;
    end
    for (int i = 0; i < cnt; i++) begin
      fk = flt(k); k++;
      push((i == cnt - 1) ? OP_RN : OP_RA, 8'h00, fk, fk != 2, fk == 2, 0, "R6", "R10");
      if (fk == 2) return;
    end
    fk = flt(k);
    push(OP_SP, 8'h00, fk, 0, 1, fk != 2, "R6", (fk == 2) ? "R10" : "R11");
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(out_valid == pend_out, "R6", "out_valid", out_valid, pend_out);
      if (pend_out && out_valid) chk(out_data == pend_val, "R6", "out_data", out_data, pend_val);
      chk(done == pend_done, pend_tag, "done", done, pend_done);
      if (pend_done && done) chk(done_ok == pend_ok, pend_tag, "done_ok", done_ok, pend_ok);
      pend_out = 0; pend_done = 0;
      chk(req_ready == exp_ready, "R12", "req_ready", req_ready, exp_ready);
      // R7: command must match the expected one on every cycle until completion
      chk(cmd_valid == (q_op.size() > 0), "R7", "cmd_valid", cmd_valid, q_op.size() > 0);
      if (cmd_valid && q_op.size() > 0) begin
        chk(cmd_op == q_op[0], q_req[0], "cmd_op", cmd_op, q_op[0]);
        chk(cmd_data == q_dat[0], q_req[0], "cmd_data", cmd_data, q_dat[0]);
      end
      if (cmd_done) begin
        cmd_done = 0; cmd_ack = 0; cmd_err = 0; lat = 0;
      end else if (cmd_valid) begin
        lat++;
        if (lat >= 1 + (cmd_seq % 3)) begin
          int fk;
          fk = (q_op.size() > 0) ? q_flt[0] : 0;
          cmd_done = 1; cmd_ack = (fk != 1); cmd_err = (fk == 2);
          if (cmd_op == OP_RA || cmd_op == OP_RN) begin
            cmd_rdata = rd_val(rd_n, req_no); rd_n++;
          end else cmd_rdata = 8'hEE;
          cmd_seq++;
          if (q_op.size() > 0) begin
            if (q_emit[0]) begin pend_out = 1; pend_val = cmd_rdata; end
            if (q_last[0]) begin
              pend_done = 1; pend_ok = q_ok[0]; pend_tag = q_tag[0];
              exp_ready = 1; n_done++;
            end
            void'(q_op.pop_front()); void'(q_dat.pop_front()); void'(q_flt.pop_front());
            void'(q_emit.pop_front()); void'(q_last.pop_front()); void'(q_ok.pop_front());
            void'(q_req.pop_front()); void'(q_tag.pop_front());
          end
        end
      end
      if (req_valid && req_ready) begin
        req_no++; rd_n = 0;
        build(req_dev, req_chan, req_mode, req_autoinc, req_aout, int'(req_count));
        n_acc++;
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic run_req(input logic [2:0] dv, input logic [1:0] ch, input logic [1:0] md,
                         input bit ai, input bit ao, input int cnt,
                         input int fi, input int fk, input bit junk);
    int a0 = n_acc;
    int d0 = n_done;
    f_idx = fi; f_kind = fk;
    @(posedge clk); #1;
    req_dev = dv; req_chan = ch; req_mode = md; req_autoinc = ai; req_aout = ao;
    req_count = cnt[CW-1:0]; req_valid = 1;
    wait (n_acc == a0 + 1);
    @(posedge clk); #1 req_valid = 0;
    if (junk) begin
      repeat (2) @(posedge clk);
      #1 req_dev = ~dv; req_count = 4'd5; req_valid = 1;
      repeat (3) @(posedge clk);
      #1 req_valid = 0;
      chk(n_acc == a0 + 1, "R12", "requests taken while busy", n_acc - a0, 1);
    end
    wait (n_done == d0 + 1);
    repeat (4) @(posedge clk);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1, "R1", "req_ready after reset", req_ready, 1);
    chk(cmd_valid == 0, "R1", "cmd_valid after reset", cmd_valid, 0);
    chk(done == 0, "R1", "done after reset", done, 0);
    chk(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
    run_req(3'd3, 2'd2, 2'd1, 1, 0, 3, -1, 0, 1);
    run_req(3'd7, 2'd0, 2'd3, 0, 1, 1, -1, 0, 0);
    run_req(3'd0, 2'd3, 2'd2, 1, 1, 15, -1, 0, 0);
    run_req(3'd5, 2'd1, 2'd0, 0, 0, 2, 0, 1, 0);
    run_req(3'd2, 2'd1, 2'd1, 0, 0, 2, 1, 1, 0);
    run_req(3'd6, 2'd0, 2'd0, 1, 0, 2, 2, 1, 0);
    run_req(3'd1, 2'd2, 2'd3, 0, 0, 2, 0, 2, 0);
    run_req(3'd1, 2'd2, 2'd3, 0, 0, 3, 3, 2, 0);
    run_req(3'd4, 2'd3, 2'd0, 1, 1, 4, 6, 2, 0);
    run_req(3'd4, 2'd0, 2'd1, 0, 0, 2, 7, 2, 0);
    run_req(3'd0, 2'd0, 2'd0, 0, 0, 0, -1, 0, 0);
    run_req(3'd3, 2'd1, 2'd2, 0, 1, 2, -1, 0, 0);
    chk(q_op.size() == 0, "R11", "commands left over", q_op.size(), 0);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule